// File: doc/BRIEF.md
# Paged SPI Register Access Sequencer

This block runs one complete register access on an SPI-attached device whose registers sit in 256-byte pages. The user side presents an operation and a one-cycle start strobe. The operation is a read or write flag, a page number, a register offset, a byte count of 1, 2, 4, 6 or 8, and write data. The block then runs the whole multi-transfer exchange by itself and reports completion with a one-cycle done pulse. An error flag accompanies done when the device never became ready.

Each access begins by reading the device status byte until its busy flag is clear, and then selects the page. A write then goes out in a single transfer. A read is a two-step handshake. The block first names the target register, polls status until the device acknowledges that the value is staged, and then clocks the value out of a fixed data window. Polls are spaced by a millisecond tick divided down from the system clock. The SPI shifting is built in: mode 0, with chip select held low for each transfer.

Top module: `paged_reg_sequencer`

## Requirements
- R1: Byte 0 of every transfer is a command byte. It is 0x60 for a read transfer and 0x61 for a write transfer; bit 0 carries the direction.
- R2: Every access starts with 3-byte status reads (0x60, 0xFE, one byte clocked in), repeated until bit 7 of the returned byte is 0. Successive polls are at least one tick period (TICK_CYCLES clocks) apart. After 10 status reads that all show bit 7 set, the access ends with an error and no further transfer.
- R3: Once the device is idle, the page is programmed by the 3-byte transfer 0x61, 0xFF, page. This happens before any transfer that touches the target register.
- R4: A read sends 0x60 followed by the register offset, and clocks in one byte to trigger the fetch. It then polls status at 0xFE until bit 5 is 1, at most 10 times, one tick apart. If bit 5 never appears, the access ends with an error.
- R5: After the acknowledge, a read issues 0x60, 0xF0 and clocks in exactly the requested number of bytes. The first byte received lands in rd_data[7:0], the next in [15:8], and so on. Bytes above the requested count read as zero.
- R6: A write sends 0x61, the offset and then exactly the requested number of data bytes in one transfer, starting with wr_data[7:0]. The 6-byte case sends wr_data[47:0].
- R7: SPI is mode 0. SCK idles low and MOSI is stable while SCK is high. Chip select is low for each transfer and high between transfers. MOSI is 0 during the bytes clocked in by a read.
- R8: done is a one-cycle pulse. error is high only together with done. rd_data is zero after an error and after a write.
- R9: A start strobe during an access is ignored. After an error the block accepts and completes the next request normally.
- R10: After reset, chip select is high, SCK is low, and done, error and rd_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, taken only when the block is idle |
| write_en | input | 1 | 1 = write access, 0 = read access |
| page | input | 8 | Register page to select |
| reg_addr | input | 8 | Register offset within the page |
| byte_len | input | 4 | Number of data bytes (1, 2, 4, 6 or 8) |
| wr_data | input | 64 | Write value, least significant byte sent first |
| rd_data | output | 64 | Assembled read value, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Device did not become ready; valid with done |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A bench device model keeps a page register, a busy countdown and a delayed read acknowledge. It logs the command and offset of every transfer. Writes of 1, 2, 6 and 8 bytes and reads of every legal length separate correct byte order and exact byte counts from truncated, over-long or reversed frames. Varying the busy and acknowledge delays shows whether the polls actually wait, and whether the block gives up after exactly ten tries in each phase. A start pulse sent mid-access, and a normal request right after a failure, show that requests are not taken while busy and that the block recovers after an error.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;

    localparam int FRAME_BYTES   = 10;
    localparam int PAYLOAD_BYTES = 8;

    localparam logic [7:0] CMD_READ    = 8'h60;
    localparam logic [7:0] CMD_WRITE   = 8'h61;
    localparam logic [7:0] OFS_STATUS  = 8'hFE;
    localparam logic [7:0] OFS_PAGESEL = 8'hFF;
    localparam logic [7:0] OFS_WINDOW  = 8'hF0;
    localparam int         BUSY_BIT    = 7;
    localparam int         ACK_BIT     = 5;

    typedef logic [8*FRAME_BYTES-1:0]   frame_t;
    typedef logic [8*PAYLOAD_BYTES-1:0] payload_t;

    typedef struct packed {
        logic [3:0] nbytes;
        frame_t     tx;
    } xfer_req_t;

    typedef struct packed {
        logic       is_write;
        logic [7:0] page;
        logic [7:0] offset;
        logic [3:0] len;
        payload_t   wdata;
    } op_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_IDLE_POLL,
        SQ_IDLE_WAIT,
        SQ_PAGE,
        SQ_WRITE,
        SQ_TRIGGER,
        SQ_ACK_POLL,
        SQ_ACK_WAIT,
        SQ_FETCH
    } seq_state_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_SHIFT,
        EN_TAIL,
        EN_GAP
    } eng_state_t;

    function automatic logic [3:0] legal_len(input logic [3:0] n);
        if (n == 4'd0)
            return 4'd1;
        else if (n > 4'd8)
            return 4'd8;
        else
            return n;
    endfunction

    function automatic payload_t keep_low_bytes(input payload_t d, input logic [3:0] n);
        payload_t r;
        r = d;
        for (int i = 0; i < PAYLOAD_BYTES; i++) begin
            if (i >= int'(n))
                r[8*i +: 8] = 8'h00;
        end
        return r;
    endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int TICK_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(TICK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_pg_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  xfer_req_t req,
    input  logic      miso,
    output logic      sck,
    output logic      cs_n,
    output logic      mosi,
    output payload_t  rx_payload,
    output logic      done
);
    localparam int DW = $clog2(HALF_DIV + 1);
    localparam logic [DW-1:0] DLAST = DW'(HALF_DIV - 1);

    eng_state_t    st;
    frame_t        tx_q;
    logic [3:0]    n_q;
    logic [3:0]    byte_idx;
    logic [2:0]    bit_idx;
    logic [DW-1:0] div;
    logic          half_end;
    logic [6:0]    pos;
    logic [5:0]    pl_pos;

    assign half_end = (div == DLAST);
    assign pos      = {byte_idx, ~bit_idx};
    assign pl_pos   = 6'(pos - 7'd16);
    assign mosi     = (st == EN_SHIFT) ? tx_q[pos] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= EN_IDLE;
            tx_q       <= '0;
            n_q        <= '0;
            byte_idx   <= '0;
            bit_idx    <= '0;
            div        <= '0;
            sck        <= 1'b0;
            cs_n       <= 1'b1;
            rx_payload <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                EN_IDLE: begin
                    if (start) begin
                        tx_q       <= req.tx;
                        n_q        <= req.nbytes;
                        byte_idx   <= '0;
                        bit_idx    <= '0;
                        div        <= '0;
                        sck        <= 1'b0;
                        cs_n       <= 1'b0;
                        rx_payload <= '0;
                        st         <= EN_SHIFT;
                    end
                end
                EN_SHIFT: begin
                    if (half_end) begin
                        div <= '0;
                        if (!sck) begin
                            sck <= 1'b1;
                            if (byte_idx >= 4'd2)
                                rx_payload[pl_pos] <= miso;
                        end else begin
                            sck <= 1'b0;
                            if (bit_idx == 3'd7) begin
                                bit_idx <= '0;
                                if (byte_idx == n_q - 4'd1)
                                    st <= EN_TAIL;
                                else
                                    byte_idx <= byte_idx + 4'd1;
                            end else begin
                                bit_idx <= bit_idx + 3'd1;
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                EN_TAIL: begin
                    if (half_end) begin
                        div  <= '0;
                        cs_n <= 1'b1;
                        st   <= EN_GAP;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
                default: begin
                    if (half_end) begin
                        div  <= '0;
                        done <= 1'b1;
                        st   <= EN_IDLE;
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/paged_access_ctrl.sv
module paged_access_ctrl
    import spi_pg_pkg::*;
#(
    parameter int MAX_TRIES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  op_t        op_in,
    input  payload_t   eng_rx,
    input  logic       eng_done,
    input  logic       tick,
    output logic       tick_run,
    output logic       eng_start,
    output xfer_req_t  eng_req,
    output payload_t   rd_data,
    output logic       done,
    output logic       error
);
    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

    seq_state_t    st;
    op_t           op_q;
    logic          issued;
    logic [TW-1:0] tries;
    xfer_req_t     req_next;
    logic [7:0]    stat_byte;
    logic          xfer_state;

    assign stat_byte = eng_rx[7:0];
    assign tick_run  = (st == SQ_IDLE_WAIT) || (st == SQ_ACK_WAIT);
    assign xfer_state = (st == SQ_IDLE_POLL) || (st == SQ_PAGE) || (st == SQ_WRITE) ||
                        (st == SQ_TRIGGER) || (st == SQ_ACK_POLL) || (st == SQ_FETCH);

    always_comb begin
        req_next = '0;
        case (st)
            SQ_IDLE_POLL, SQ_ACK_POLL: begin
                req_next.nbytes = 4'd3;
                req_next.tx     = {64'h0, OFS_STATUS, CMD_READ};
            end
            SQ_PAGE: begin
                req_next.nbytes = 4'd3;
                req_next.tx     = {56'h0, op_q.page, OFS_PAGESEL, CMD_WRITE};
            end
            SQ_WRITE: begin
                req_next.nbytes = op_q.len + 4'd2;
                req_next.tx     = {op_q.wdata, op_q.offset, CMD_WRITE};
            end
            SQ_TRIGGER: begin
                req_next.nbytes = 4'd3;
                req_next.tx     = {64'h0, op_q.offset, CMD_READ};
            end
            SQ_FETCH: begin
                req_next.nbytes = op_q.len + 4'd2;
                req_next.tx     = {64'h0, OFS_WINDOW, CMD_READ};
            end
            default: req_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            op_q      <= '0;
            issued    <= 1'b0;
            tries     <= '0;
            eng_start <= 1'b0;
            eng_req   <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
            error     <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            done      <= 1'b0;
            error     <= 1'b0;

            if (xfer_state && !issued) begin
                eng_start <= 1'b1;
                eng_req   <= req_next;
                issued    <= 1'b1;
            end

            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        op_q     <= op_in;
                        op_q.len <= legal_len(op_in.len);
                        tries    <= '0;
                        issued   <= 1'b0;
                        st       <= SQ_IDLE_POLL;
                    end
                end
                SQ_IDLE_POLL: begin
                    if (issued && eng_done) begin
                        issued <= 1'b0;
                        if (!stat_byte[BUSY_BIT]) begin
                            tries <= '0;
                            st    <= SQ_PAGE;
                        end else if (tries == TRY_LAST) begin
                            rd_data <= '0;
                            done    <= 1'b1;
                            error   <= 1'b1;
                            st      <= SQ_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= SQ_IDLE_WAIT;
                        end
                    end
                end
                SQ_IDLE_WAIT: begin
                    if (tick)
                        st <= SQ_IDLE_POLL;
                end
                SQ_PAGE: begin
                    if (issued && eng_done) begin
                        issued <= 1'b0;
                        st     <= op_q.is_write ? SQ_WRITE : SQ_TRIGGER;
                    end
                end
                SQ_WRITE: begin
                    if (issued && eng_done) begin
                        issued  <= 1'b0;
                        rd_data <= '0;
                        done    <= 1'b1;
                        st      <= SQ_IDLE;
                    end
                end
                SQ_TRIGGER: begin
                    if (issued && eng_done) begin
                        issued <= 1'b0;
                        tries  <= '0;
                        st     <= SQ_ACK_POLL;
                    end
                end
                SQ_ACK_POLL: begin
                    if (issued && eng_done) begin
                        issued <= 1'b0;
                        if (stat_byte[ACK_BIT]) begin
                            st <= SQ_FETCH;
                        end else if (tries == TRY_LAST) begin
                            rd_data <= '0;
                            done    <= 1'b1;
                            error   <= 1'b1;
                            st      <= SQ_IDLE;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= SQ_ACK_WAIT;
                        end
                    end
                end
                SQ_ACK_WAIT: begin
                    if (tick)
                        st <= SQ_ACK_POLL;
                end
                SQ_FETCH: begin
                    if (issued && eng_done) begin
                        issued  <= 1'b0;
                        rd_data <= keep_low_bytes(eng_rx, op_q.len);
                        done    <= 1'b1;
                        st      <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/paged_reg_sequencer.sv
module paged_reg_sequencer
    import spi_pg_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int TICK_CYCLES = 50000,
    parameter int MAX_TRIES   = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        write_en,
    input  logic [7:0]  page,
    input  logic [7:0]  reg_addr,
    input  logic [3:0]  byte_len,
    input  logic [63:0] wr_data,
    output logic [63:0] rd_data,
    output logic        done,
    output logic        error,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    op_t       op_in;
    xfer_req_t eng_req;
    payload_t  eng_rx;
    logic      eng_start;
    logic      eng_done;
    logic      tick;
    logic      tick_run;

    assign op_in.is_write = write_en;
    assign op_in.page     = page;
    assign op_in.offset   = reg_addr;
    assign op_in.len      = byte_len;
    assign op_in.wdata    = wr_data;

    ms_tick_gen #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (tick_run),
        .tick (tick)
    );

    paged_access_ctrl #(
        .MAX_TRIES(MAX_TRIES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_in     (op_in),
        .eng_rx    (eng_rx),
        .eng_done  (eng_done),
        .tick      (tick),
        .tick_run  (tick_run),
        .eng_start (eng_start),
        .eng_req   (eng_req),
        .rd_data   (rd_data),
        .done      (done),
        .error     (error)
    );

    spi_frame_engine #(
        .HALF_DIV(HALF_DIV)
    ) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .req        (eng_req),
        .miso       (spi_miso),
        .sck        (spi_sck),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .rx_payload (eng_rx),
        .done       (eng_done)
    );

endmodule

// File: rtl/paged_seq_checker.sv
module paged_seq_checker (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        error,
    input logic [63:0] rd_data,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic        spi_mosi
);
    // R8: error never appears without the completion pulse
    a_r8_error_with_done: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R8: completion lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: failed access leaves no read value behind
    a_r8_zero_on_error: assert property (@(posedge clk) disable iff (rst)
        error |-> (rd_data == 64'h0));

    // R7: clock parked low whenever the device is deselected
    a_r7_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R7: data line holds while the clock is high
    a_r7_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

endmodule

bind paged_reg_sequencer paged_seq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .error    (error),
    .rd_data  (rd_data),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi)
);

// File: tb/paged_reg_sequencer_test.sv
module paged_reg_sequencer_test;

    localparam int TICK = 40;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        write_en;
    logic [7:0]  page;
    logic [7:0]  reg_addr;
    logic [3:0]  byte_len;
    logic [63:0] wr_data;
    logic [63:0] rd_data;
    logic        done;
    logic        error;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    paged_reg_sequencer #(
        .HALF_DIV(2), .TICK_CYCLES(TICK), .MAX_TRIES(10)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .write_en(write_en), .page(page),
        .reg_addr(reg_addr), .byte_len(byte_len), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .error(error), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- device model ----------------
    int          busy_left = 0;
    int          ack_delay = 0;
    int          ack_left  = 0;
    bit          ack_pend  = 0;
    logic [7:0]  dev_page  = 8'h00;
    logic [63:0] win_val   = '0;
    logic [7:0]  wr_page_seen;
    logic [7:0]  wr_addr_seen;
    logic [63:0] wr_data_seen;
    int          wr_n_seen;
    int          wr_count;
    int          stat_reads;
    bit          mosi_nz;
    logic [7:0]  log_cmd [0:31];
    logic [7:0]  log_ofs [0:31];
    int          log_n;

    function automatic logic [63:0] win_fn(input logic [7:0] p, input logic [7:0] a);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = p ^ (a + 8'(k*37 + 5));
        return v;
    endfunction

    function automatic logic [63:0] low_bytes(input logic [63:0] d, input int n);
        logic [63:0] v;
        v = d;
        for (int k = 0; k < 8; k++) if (k >= n) v[8*k +: 8] = 8'h00;
        return v;
    endfunction

    task automatic clear_logs();
        wr_page_seen = 8'hxx; wr_addr_seen = 8'h00; wr_data_seen = '0;
        wr_n_seen = 0; wr_count = 0; stat_reads = 0; mosi_nz = 0; log_n = 0;
    endtask

    initial begin
        logic [7:0] cmd, ofs, ob, ib, first_data;
        int nb;
        bit act;
        spi_miso = 1'b0;
        forever begin
            @(negedge spi_cs_n);
            nb = 0; act = 1; cmd = 0; ofs = 0; first_data = 0;
            while (act) begin
                ob = 8'h00;
                if (nb >= 2 && cmd == 8'h60) begin
                    if (ofs == 8'hFE)
                        ob = {busy_left > 0, 1'b0, ack_pend && ack_left == 0, 5'b0};
                    else if (ofs == 8'hF0 && nb < 10)
                        ob = win_val[8*(nb-2) +: 8];
                end
                for (int b = 7; b >= 0; b--) begin
                    if (act) begin
                        spi_miso = ob[b];
                        @(posedge spi_sck or posedge spi_cs_n);
                        if (spi_cs_n) act = 0;
                        else begin
                            ib[b] = spi_mosi;
                            @(negedge spi_sck);
                        end
                    end
                end
                if (act) begin
                    if (nb == 0) cmd = ib;
                    else if (nb == 1) ofs = ib;
                    else begin
                        if (nb == 2) first_data = ib;
                        if (cmd == 8'h61 && nb < 10) wr_data_seen[8*(nb-2) +: 8] = ib;
                        if (cmd == 8'h60 && ib != 8'h00) mosi_nz = 1;
                    end
                    nb++;
                end
            end
            spi_miso = 1'b0;
            if (log_n < 32) begin log_cmd[log_n] = cmd; log_ofs[log_n] = ofs; end
            log_n++;
            if (cmd == 8'h61) begin
                if (ofs == 8'hFF) dev_page = first_data;
                else begin
                    wr_page_seen = dev_page; wr_addr_seen = ofs;
                    wr_n_seen = nb - 2; wr_count++;
                end
            end else if (cmd == 8'h60) begin
                if (ofs == 8'hFE) begin
                    stat_reads++;
                    if (busy_left > 0) busy_left--;
                    else if (ack_pend && ack_left > 0) ack_left--;
                end else if (ofs == 8'hF0) begin
                    ack_pend = 0;
                end else begin
                    ack_pend = 1; ack_left = ack_delay; win_val = win_fn(dev_page, ofs);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [7:0] pg, input logic [7:0] ofs,
                          input int len, input logic [63:0] wd,
                          output logic [63:0] got, output logic err, output int took);
        int t0;
        @(negedge clk);
        write_en = wr; page = pg; reg_addr = ofs; byte_len = 4'(len); wr_data = wd;
        start = 1'b1; t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        got = rd_data; err = error; took = cyc - t0;
        @(negedge clk);
        check(done == 1'b0, "R8 done pulse width", done, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R10 sck", spi_sck, 0);
        check(done == 1'b0 && error == 1'b0, "R10 done/error", {done, error}, 0);
        check(rd_data == 64'h0, "R10 rd_data", rd_data, 0);
    endtask

    task automatic t_write(input logic [7:0] pg, input logic [7:0] ofs, input int len, input logic [63:0] wd);
        logic [63:0] got; logic err; int took;
        clear_logs(); busy_left = 0;
        run_op(1, pg, ofs, len, wd, got, err, took);
        check(err == 1'b0, "R6 write no error", err, 0);
        check(log_n == 3, "R3 write transfer count", log_n, 3);
        check(log_cmd[0] == 8'h60 && log_ofs[0] == 8'hFE, "R2 first transfer polls status",
              {log_cmd[0], log_ofs[0]}, 16'h60FE);
        check(log_cmd[1] == 8'h61 && log_ofs[1] == 8'hFF, "R3 page select frame",
              {log_cmd[1], log_ofs[1]}, 16'h61FF);
        check(log_cmd[2] == 8'h61 && log_ofs[2] == ofs, "R1 write command byte",
              {log_cmd[2], log_ofs[2]}, {8'h61, ofs});
        check(wr_page_seen == pg, "R3 page applied before write", wr_page_seen, pg);
        check(wr_n_seen == len, "R6 exact data byte count", wr_n_seen, len);
        check(wr_data_seen == low_bytes(wd, len), "R6 data LSB first", wr_data_seen, low_bytes(wd, len));
        check(got == 64'h0, "R8 rd_data zero after write", got, 0);
    endtask

    task automatic t_read(input logic [7:0] pg, input logic [7:0] ofs, input int len, input int ackd);
        logic [63:0] got, exp; logic err; int took;
        clear_logs(); busy_left = 0; ack_delay = ackd;
        run_op(0, pg, ofs, len, 64'hFFFF_FFFF_FFFF_FFFF, got, err, took);
        exp = low_bytes(win_fn(pg, ofs), len);
        check(err == 1'b0, "R4 read no error", err, 0);
        check(got == exp, "R5 assembled read value", got, exp);
        check(log_n == 5 + ackd, "R4 read transfer count", log_n, 5 + ackd);
        check(log_cmd[2] == 8'h60 && log_ofs[2] == ofs, "R1 read trigger command",
              {log_cmd[2], log_ofs[2]}, {8'h60, ofs});
        check(log_ofs[3] == 8'hFE && log_ofs[4 + ackd] == 8'hF0, "R4 ack poll then window",
              {log_ofs[3], log_ofs[4 + ackd]}, 16'hFEF0);
        check(stat_reads == 2 + ackd, "R4 ack poll count", stat_reads, 2 + ackd);
        check(mosi_nz == 0, "R7 MOSI zero while reading", mosi_nz, 0);
    endtask

    task automatic t_busy_wait();
        logic [63:0] got; logic err; int took;
        clear_logs(); busy_left = 3; ack_delay = 0;
        run_op(0, 8'h12, 8'h34, 4, '0, got, err, took);
        check(err == 1'b0, "R2 busy clears in time", err, 0);
        check(stat_reads == 5, "R2 idle poll repeats", stat_reads, 5);
        check(took >= 3 * TICK, "R2 poll spacing", took, 3 * TICK);
        check(got == low_bytes(win_fn(8'h12, 8'h34), 4), "R5 read after busy", got,
              low_bytes(win_fn(8'h12, 8'h34), 4));
    endtask

    task automatic t_busy_timeout();
        logic [63:0] got; logic err; int took; logic [7:0] pg_before;
        clear_logs(); busy_left = 1000; pg_before = dev_page;
        run_op(1, 8'hA5, 8'h10, 2, 64'h1234, got, err, took);
        check(err == 1'b1, "R2 busy timeout error", err, 1);
        check(got == 64'h0, "R8 rd_data zero on error", got, 0);
        check(stat_reads == 10, "R2 ten status tries", stat_reads, 10);
        check(log_n == 10 && wr_count == 0 && dev_page == pg_before, "R2 nothing after timeout",
              log_n, 10);
        check(took >= 9 * TICK, "R2 timeout spacing", took, 9 * TICK);
        busy_left = 0;
    endtask

    task automatic t_ack_timeout();
        logic [63:0] got; logic err; int took;
        clear_logs(); busy_left = 0; ack_delay = 100;
        run_op(0, 8'h03, 8'h44, 8, '0, got, err, took);
        check(err == 1'b1, "R4 ack timeout error", err, 1);
        check(got == 64'h0, "R8 rd_data zero after ack timeout", got, 0);
        check(stat_reads == 11, "R4 ten ack tries", stat_reads, 11);
        check(log_n == 13, "R4 no window read after timeout", log_n, 13);
        ack_delay = 0;
        ack_pend = 0;
    endtask

    task automatic t_start_ignored();
        clear_logs(); busy_left = 0;
        @(negedge clk);
        write_en = 1; page = 8'h21; reg_addr = 8'h08; byte_len = 4'd2; wr_data = 64'hBEEF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        reg_addr = 8'h09; wr_data = 64'h1111; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (600) @(negedge clk);
        check(wr_count == 1, "R9 mid-access start ignored", wr_count, 1);
        check(wr_addr_seen == 8'h08 && wr_data_seen == 64'hBEEF, "R9 first request kept",
              {wr_addr_seen, wr_data_seen[55:0]}, {8'h08, 56'hBEEF});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; write_en = 0; page = 0; reg_addr = 0; byte_len = 0; wr_data = 0;
        clear_logs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write(8'h05, 8'h20, 1, 64'h0000_0000_0000_00C3);
        t_write(8'h06, 8'h22, 2, 64'h1122_3344_5566_A55A);
        t_write(8'h07, 8'h30, 6, 64'hDEAD_0102_0304_0506);
        t_write(8'h08, 8'h40, 8, 64'h0123_4567_89AB_CDEF);
        t_read(8'h10, 8'h02, 1, 0);
        t_read(8'h11, 8'h04, 2, 0);
        t_read(8'h12, 8'h06, 4, 2);
        t_read(8'h13, 8'h08, 6, 0);
        t_read(8'h14, 8'h0A, 8, 1);
        t_busy_wait();
        t_busy_timeout();
        t_write(8'h33, 8'h50, 4, 64'h0000_0000_CAFE_F00D);  // R9 recovery after error
        t_ack_timeout();
        t_read(8'h44, 8'h18, 8, 0);                         // R9 recovery after ack failure
        t_start_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule